// File: doc/BRIEF.md
# Processor Status Word with Interrupt Gating

This block holds the 16-bit status word of a small CPU core. It keeps the four arithmetic flags, the register-bank select, the stack-pointer select, the single-step enable, the interrupt enable and a 3-bit processor priority level. The ALU side sends per-flag update enables with result values. The sequencer can overwrite the whole word, pulse a hardware interrupt acknowledge, or signal a software interrupt together with its number.

From the stored word the block drives the bank select and stack select straight to the register file and stack logic. It raises a single-step request when an instruction retires with stepping enabled. It also decides, combinationally, whether the pending maskable interrupt may be taken this cycle. The block exchanges no data stream, so every pin is a plain control or status signal with no handshake. Vector fetch, context stacking and the ALU lie outside it.

Top module: `psw_status_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, psw reads 0x0000.
- R2: Bit positions are carry 0, step-enable 1, zero 2, sign 3, bank 4, overflow 5, interrupt-enable 6, user-stack 7, and the priority level in bits 14:12. Bits 11:8 and bit 15 always read 0, whatever is written to them.
- R3: alu_we and alu_val index the flags as [0]=carry, [1]=zero, [2]=sign, [3]=overflow. On a clock edge with no full-word write, each enabled flag takes its alu_val bit (set when the condition held, cleared otherwise), and each disabled flag keeps its value.
- R4: When word_we is high at a clock edge, psw takes word_wdata (reserved bits forced to 0) and all ALU updates of that cycle are ignored.
- R5: A hw_ack at a clock edge clears step-enable, interrupt-enable and user-stack, even when a full-word write or an ALU update happens in the same cycle.
- R6: An sw_int at a clock edge clears step-enable and interrupt-enable. It also clears user-stack when sw_num is below 32, and leaves user-stack as it would otherwise be when sw_num is 32 or above.
- R7: irq_take is high exactly when irq_pend is high, interrupt-enable is 1, and irq_lvl is strictly greater than the stored priority level.
- R8: step_req is high exactly when insn_done is high and step-enable is 1.
- R9: bank_sel equals the bank bit (0 selects bank 0, 1 selects bank 1), and sp_user_sel equals the user-stack bit (0 selects the interrupt stack, 1 selects the user stack).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 4 | Per-flag update enables: carry, zero, sign, overflow |
| alu_val | input | 4 | Per-flag new values, same order as alu_we |
| word_we | input | 1 | Full-word write strobe |
| word_wdata | input | 16 | Full-word write data |
| hw_ack | input | 1 | Hardware interrupt acknowledge pulse |
| sw_int | input | 1 | Software interrupt taken pulse |
| sw_num | input | 6 | Software interrupt number |
| insn_done | input | 1 | Instruction retired this cycle |
| irq_pend | input | 1 | A maskable interrupt is pending |
| irq_lvl | input | 3 | Priority of the pending interrupt |
| psw | output | 16 | Stored status word |
| bank_sel | output | 1 | Register bank select |
| sp_user_sel | output | 1 | Stack pointer select |
| step_req | output | 1 | Single-step interrupt request |
| irq_take | output | 1 | Pending interrupt may be accepted |

## Verification
Directed cycles first aim the priority comparison at a request level equal to the stored level, one above it, and at either end of the range, with the enable on and off. This separates a strict comparison from a greater-or-equal one. Software interrupts numbered 31 and 32 mark the edge where the stack select stops being cleared. Cycles that combine a word write, an ALU update and an acknowledge show the precedence order. A long stretch of random cycles, weighted towards writes that set the interrupt enable, then runs every mix of flag enables and events against the bench model every cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W   = 16;
  localparam int BIT_C   = 0;
  localparam int BIT_D   = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_S   = 3;
  localparam int BIT_B   = 4;
  localparam int BIT_O   = 5;
  localparam int BIT_I   = 6;
  localparam int BIT_U   = 7;
  localparam int LVL_LSB = 12;
  localparam int LVL_W   = 3;
  localparam int NUM_ALU = 4;

  // ALU flag slot k -> bit position in the word (slot order: C, Z, S, O)
  function automatic int alu_pos(input int k);
    case (k)
      0:       return BIT_C;
      1:       return BIT_Z;
      2:       return BIT_S;
      default: return BIT_O;
    endcase
  endfunction

  // Bits that hold state; everything else is reserved and reads 0
  function automatic logic [PSW_W-1:0] live_mask();
    logic [PSW_W-1:0] m;
    m = '0;
    for (int b = 0; b <= BIT_U; b++) m[b] = 1'b1;
    for (int b = 0; b < LVL_W; b++) m[LVL_LSB+b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/psw_ack_ctl.sv
module psw_ack_ctl #(
  parameter int SWNUM_W    = 6,
  parameter int SW_U_LIMIT = 32
) (
  input  logic               hw_ack,
  input  logic               sw_int,
  input  logic [SWNUM_W-1:0] sw_num,
  output logic               clr_step_ie,
  output logic               clr_user
);
  localparam int NUM_SPAN = 1 << SWNUM_W;
  logic sw_low;

  generate
    if (SW_U_LIMIT >= NUM_SPAN) begin : g_all_low
      assign sw_low = 1'b1;
    end else begin : g_cmp
      assign sw_low = (int'(sw_num) < SW_U_LIMIT);
    end
  endgenerate

  assign clr_step_ie = hw_ack | sw_int;
  assign clr_user    = hw_ack | (sw_int & sw_low);
endmodule

// File: rtl/psw_flag_store.sv
module psw_flag_store
  import psw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ALU-1:0] alu_we,
  input  logic [NUM_ALU-1:0] alu_val,
  input  logic               word_we,
  input  logic [PSW_W-1:0]   word_wdata,
  input  logic               clr_step_ie,
  input  logic               clr_user,
  output logic [PSW_W-1:0]   q
);
  localparam logic [PSW_W-1:0] MASK = live_mask();
  logic [PSW_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (word_we) begin
      nxt = word_wdata & MASK;
    end else begin
      for (int k = 0; k < NUM_ALU; k++) begin
        if (alu_we[k]) nxt[alu_pos(k)] = alu_val[k];
      end
    end
    if (clr_step_ie) begin
      nxt[BIT_D] = 1'b0;
      nxt[BIT_I] = 1'b0;
    end
    if (clr_user) nxt[BIT_U] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
  parameter int LW = 3
) (
  input  logic          irq_pend,
  input  logic          ie,
  input  logic [LW-1:0] irq_lvl,
  input  logic [LW-1:0] cur_lvl,
  input  logic          step_en,
  input  logic          insn_done,
  output logic          irq_take,
  output logic          step_req
);
  assign irq_take = irq_pend & ie & (irq_lvl > cur_lvl);
  assign step_req = insn_done & step_en;
endmodule

// File: rtl/psw_status_unit.sv
module psw_status_unit
  import psw_pkg::*;
#(
  parameter int SWNUM_W    = 6,
  parameter int SW_U_LIMIT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         alu_we,
  input  logic [3:0]         alu_val,
  input  logic               word_we,
  input  logic [15:0]        word_wdata,
  input  logic               hw_ack,
  input  logic               sw_int,
  input  logic [SWNUM_W-1:0] sw_num,
  input  logic               insn_done,
  input  logic               irq_pend,
  input  logic [2:0]         irq_lvl,
  output logic [15:0]        psw,
  output logic               bank_sel,
  output logic               sp_user_sel,
  output logic               step_req,
  output logic               irq_take
);
  logic clr_step_ie, clr_user;

  psw_ack_ctl #(.SWNUM_W(SWNUM_W), .SW_U_LIMIT(SW_U_LIMIT)) u_ack (
    .hw_ack(hw_ack), .sw_int(sw_int), .sw_num(sw_num),
    .clr_step_ie(clr_step_ie), .clr_user(clr_user)
  );

  psw_flag_store u_store (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
    .word_we(word_we), .word_wdata(word_wdata),
    .clr_step_ie(clr_step_ie), .clr_user(clr_user), .q(psw)
  );

  psw_irq_gate #(.LW(LVL_W)) u_gate (
    .irq_pend(irq_pend), .ie(psw[BIT_I]), .irq_lvl(irq_lvl),
    .cur_lvl(psw[LVL_LSB +: LVL_W]), .step_en(psw[BIT_D]),
    .insn_done(insn_done), .irq_take(irq_take), .step_req(step_req)
  );

  assign bank_sel    = psw[BIT_B];
  assign sp_user_sel = psw[BIT_U];
endmodule

// File: rtl/psw_status_chk.sv
module psw_status_chk
  import psw_pkg::*;
#(
  parameter int SWNUM_W    = 6,
  parameter int SW_U_LIMIT = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         alu_we,
  input logic [3:0]         alu_val,
  input logic               word_we,
  input logic [15:0]        word_wdata,
  input logic               hw_ack,
  input logic               sw_int,
  input logic [SWNUM_W-1:0] sw_num,
  input logic               insn_done,
  input logic               irq_pend,
  input logic [2:0]         irq_lvl,
  input logic [15:0]        psw,
  input logic               bank_sel,
  input logic               sp_user_sel,
  input logic               step_req,
  input logic               irq_take
);
  localparam logic [15:0] RSV = ~live_mask();

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psw & RSV) == 16'h0);

  p_carry_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && alu_we[0] && !hw_ack && !sw_int) |=> psw[BIT_C] == $past(alu_val[0]));

  p_word_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !hw_ack && !sw_int) |=> psw == ($past(word_wdata) & ~RSV));

  p_hw_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> (!psw[BIT_D] && !psw[BIT_I] && !sp_user_sel));

  p_sw_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_int && int'(sw_num) < SW_U_LIMIT) |=> (!psw[BIT_D] && !psw[BIT_I] && !psw[BIT_U]));

  p_sw_high_keeps_u_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_int && int'(sw_num) >= SW_U_LIMIT && !hw_ack && !word_we)
      |=> psw[BIT_U] == $past(psw[BIT_U]));

  p_take_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_pend && psw[BIT_I] && irq_lvl > psw[LVL_LSB +: LVL_W]));

  p_step_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (insn_done && psw[BIT_D]));

  p_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel == psw[BIT_B]) && (sp_user_sel == psw[BIT_U]));
endmodule

bind psw_status_unit psw_status_chk #(.SWNUM_W(SWNUM_W), .SW_U_LIMIT(SW_U_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
  .word_we(word_we), .word_wdata(word_wdata), .hw_ack(hw_ack),
  .sw_int(sw_int), .sw_num(sw_num), .insn_done(insn_done),
  .irq_pend(irq_pend), .irq_lvl(irq_lvl), .psw(psw), .bank_sel(bank_sel),
  .sp_user_sel(sp_user_sel), .step_req(step_req), .irq_take(irq_take)
);

// File: tb/psw_status_unit_test.sv
module psw_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_we = '0;
  logic [3:0]  alu_val = '0;
  logic        word_we = 1'b0;
  logic [15:0] word_wdata = '0;
  logic        hw_ack = 1'b0;
  logic        sw_int = 1'b0;
  logic [5:0]  sw_num = '0;
  logic        insn_done = 1'b0;
  logic        irq_pend = 1'b0;
  logic [2:0]  irq_lvl = '0;
  logic [15:0] psw;
  logic        bank_sel, sp_user_sel, step_req, irq_take;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = '0;
  string tag = "R3";

  always #2 clk = ~clk;

  psw_status_unit uut (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
    .word_we(word_we), .word_wdata(word_wdata), .hw_ack(hw_ack),
    .sw_int(sw_int), .sw_num(sw_num), .insn_done(insn_done),
    .irq_pend(irq_pend), .irq_lvl(irq_lvl), .psw(psw), .bank_sel(bank_sel),
    .sp_user_sel(sp_user_sel), .step_req(step_req), .irq_take(irq_take)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: what the word becomes after one edge
  function automatic logic [15:0] predict(input logic [15:0] cur);
    logic [15:0] n;
    n = cur;
    if (word_we) n = word_wdata & 16'h70FF;
    else begin
      if (alu_we[0]) n[0] = alu_val[0];
      if (alu_we[1]) n[2] = alu_val[1];
      if (alu_we[2]) n[3] = alu_val[2];
      if (alu_we[3]) n[5] = alu_val[3];
    end
    if (hw_ack || sw_int) begin n[1] = 1'b0; n[6] = 1'b0; end
    if (hw_ack || (sw_int && sw_num < 6'd32)) n[7] = 1'b0;
    return n;
  endfunction

  // One cycle: inputs already set at the falling edge
  task automatic cycle();
    int lvl;
    #1;
    lvl = model[14:12];
    check("R7", irq_take, (irq_pend && model[6] && irq_lvl > lvl) ? 1 : 0);
    check("R8", step_req, (insn_done && model[1]) ? 1 : 0);
    if (hw_ack) tag = "R5";
    else if (sw_int) tag = "R6";
    else if (word_we) tag = "R4";
    else tag = "R3";
    @(posedge clk);
    model = predict(model);
    @(negedge clk);
    check(tag, psw, model);
    check("R2", psw & 16'h8F00, 0);
    check("R9", {bank_sel, sp_user_sel}, {model[4], model[7]});
  endtask

  task automatic idle();
    alu_we = '0; word_we = 0; hw_ack = 0; sw_int = 0;
    insn_done = 0; irq_pend = 0;
  endtask

  task automatic wr(input logic [15:0] v);
    idle(); word_we = 1; word_wdata = v; cycle();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", psw, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", psw, 0);

    // R2: reserved bits ignored
    wr(16'hFFFF);
    // R7: level equal vs one above, strict comparison
    wr(16'h3040);
    idle(); irq_pend = 1; irq_lvl = 3; cycle();
    idle(); irq_pend = 1; irq_lvl = 4; cycle();
    idle(); irq_pend = 1; irq_lvl = 7; cycle();
    wr(16'h3000);
    idle(); irq_pend = 1; irq_lvl = 7; cycle();
    wr(16'h0040);
    idle(); irq_pend = 1; irq_lvl = 0; cycle();
    idle(); irq_pend = 1; irq_lvl = 1; cycle();
    // R8: step request
    wr(16'h0002);
    idle(); insn_done = 1; cycle();
    // R3: individual flag enables
    idle(); alu_we = 4'b0101; alu_val = 4'b1111; cycle();
    idle(); alu_we = 4'b1010; alu_val = 4'b1010; cycle();
    idle(); alu_we = 4'b1111; alu_val = 4'b0000; cycle();
    // R4: write beats ALU
    idle(); word_we = 1; word_wdata = 16'h0010; alu_we = 4'hF; alu_val = 4'hF; cycle();
    // R6: numbers 31 and 32
    wr(16'h00C2);
    idle(); sw_int = 1; sw_num = 6'd32; cycle();
    wr(16'h00C2);
    idle(); sw_int = 1; sw_num = 6'd31; cycle();
    wr(16'h00C2);
    idle(); sw_int = 1; sw_num = 6'd63; cycle();
    // R5: acknowledge beats write
    idle(); hw_ack = 1; word_we = 1; word_wdata = 16'h70FF; cycle();
    idle(); hw_ack = 1; alu_we = 4'hF; alu_val = 4'hF; cycle();

    for (int n = 0; n < 3000; n++) begin
      idle();
      alu_we = 4'($urandom);
      alu_val = 4'($urandom);
      word_we = ($urandom_range(0, 5) == 0);
      word_wdata = 16'($urandom) | 16'h0040;
      hw_ack = ($urandom_range(0, 9) == 0);
      sw_int = ($urandom_range(0, 9) == 0);
      sw_num = 6'($urandom);
      insn_done = 1'($urandom);
      irq_pend = 1'($urandom);
      irq_lvl = 3'($urandom);
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule